// File: doc/BRIEF.md
# Landing pad expectation tracker

This block keeps the one-bit forward-edge control-flow-integrity state of a small hart. The state is either idle or armed. An indirect call or jump that retires in a mode whose enable is set arms it, and only a landing-pad instruction disarms it. A non-landing-pad instruction that retires while the state is armed produces a one-cycle violation report carrying the software-check cause code. The state is then left armed for the trap handler to save.

On trap entry the live state is copied into a saved bit in the status register and cleared. Which saved bit receives the copy depends on the privilege level the trap is taken into. On trap return the live state is reloaded from the saved bit of the mode being left, and that saved bit is cleared.

The per-mode enables and the saved bits are reached through a small CSR port. Its reads are combinational and its writes take effect at the clock edge. Only the bits that belong to this feature are stored. Every other bit and every other address reads as zero.

Top module: `lpad_tracker`

## Requirements
- R1: After reset the live state is idle, `viol_valid` is 0, `viol_cause` is 0, and every enable bit and saved bit reads 0.
- R2: A retire with `rt_kind` = 1 (indirect call or jump), while the enable of `cur_priv` is set, arms the state on the next clock edge. The enables are chosen by `cur_priv`: mode 3 (machine) uses address 0x747 bit 10, mode 1 (supervisor) uses address 0x30A bit 2, and mode 0 (user) uses address 0x10A bit 2. Mode 2 never arms.
- R3: An indirect retire while the enable of the current mode is clear leaves the state idle. This holds even when the enables of other modes are set.
- R4: While armed, a retire with `rt_kind` = 2 (landing pad) returns the state to idle. A retire of any other kind (0 or 3, or a second indirect) leaves the state armed. It also raises `viol_valid` for exactly the cycle after the retire, with `viol_cause` = 18.
- R5: A landing-pad retire or an ordinary retire while idle changes nothing and raises no violation.
- R6: On trap entry the live state is copied into address 0x300 bit 23 when `trap_tgt_priv` is not 3, or into the machine saved bit when it is 3. The live state is then idle.
- R7: On trap return the live state takes the saved bit of the mode being left. `trap_ret_priv` = 3 selects the machine saved bit, and any other value selects bit 23. That saved bit is then cleared.
- R8: Priority runs trap entry first, then trap return, then retire. A retire in the same cycle as a trap entry or trap return is ignored and raises no violation.
- R9: Address 0x100 shows bit 23 only. A write to 0x100 updates bit 23 and leaves the machine saved bit unchanged.
- R10: With `HAS_LPAD` = 0 the enable and saved bits read 0 and ignore writes, so the state never arms.
- R11: The hypervisor enable (address 0x60A bit 2) is writable only when `XLEN` = 64. The machine saved bit is address 0x300 bit 41 when `XLEN` = 64, and address 0x310 bit 9 when `XLEN` = 32. Unmapped addresses read 0.
- R12: In a cycle where trap entry or trap return updates a saved bit, that update wins over a CSR write to the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_priv | input | 2 | Current privilege mode (0 user, 1 supervisor, 3 machine) |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_kind | input | 2 | Retire kind: 0 ordinary, 1 indirect call/jump, 2 landing pad |
| trap_enter | input | 1 | Trap entry pulse |
| trap_tgt_priv | input | 2 | Mode the trap is taken into |
| trap_ret | input | 1 | Trap return pulse |
| trap_ret_priv | input | 2 | Mode being returned from |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| lp_expected | output | 1 | Live state: 1 when a landing pad is expected |
| viol_valid | output | 1 | One-cycle violation report |
| viol_cause | output | CAUSE_W | Cause code of the report, 18 when valid, else 0 |

## Verification
A wrong live state shows on `lp_expected` one edge after the retire or trap that caused it. It then surfaces again one edge after the next ordinary retire, as a missing or spurious `viol_valid`. A wrong saved bit stays hidden until it is read back at 0x300, 0x100 or 0x310, or until a trap return reloads it into `lp_expected`. For that reason the tests read the status view after every trap entry and before every return. Priority faults appear only when events share a cycle, so the tests drive trap entry together with a retire and with a CSR write.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

   typedef enum logic [1:0] {
      PRIV_U = 2'd0,
      PRIV_S = 2'd1,
      PRIV_H = 2'd2,
      PRIV_M = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      RK_OTHER    = 2'd0,
      RK_INDIRECT = 2'd1,
      RK_LPAD     = 2'd2,
      RK_RSVD     = 2'd3
   } rkind_e;

   localparam logic [11:0] A_MSTATUS  = 12'h300;
   localparam logic [11:0] A_MSTATUSH = 12'h310;
   localparam logic [11:0] A_SSTATUS  = 12'h100;
   localparam logic [11:0] A_MENVCFG  = 12'h30A;
   localparam logic [11:0] A_SENVCFG  = 12'h10A;
   localparam logic [11:0] A_HENVCFG  = 12'h60A;
   localparam logic [11:0] A_MSECCFG  = 12'h747;

   localparam int B_ENV_EN  = 2;
   localparam int B_MSEC_EN = 10;
   localparam int B_SSAVE   = 23;
   localparam int SWCHK_CAUSE = 18;

   function automatic int msave_bit(input int xlen);
      return (xlen == 64) ? 41 : 9;
   endfunction

   function automatic logic [11:0] msave_addr(input int xlen);
      return (xlen == 64) ? A_MSTATUS : A_MSTATUSH;
   endfunction

endpackage

// File: rtl/lpad_cfg_regs.sv
module lpad_cfg_regs
   import lpad_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit HAS_LPAD = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  cur_priv,
   input  logic        csr_we,
   input  logic [11:0] csr_addr,
   input  logic        wd_env,
   input  logic        wd_msec,
   output logic        m_en,
   output logic        menv_en,
   output logic        senv_en,
   output logic        henv_en,
   output logic        en_cur
);

   logic wr_any;
   assign wr_any = csr_we && HAS_LPAD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en    <= 1'b0;
         menv_en <= 1'b0;
         senv_en <= 1'b0;
      end else if (wr_any) begin
         if (csr_addr == A_MSECCFG) m_en    <= wd_msec;
         if (csr_addr == A_MENVCFG) menv_en <= wd_env;
         if (csr_addr == A_SENVCFG) senv_en <= wd_env;
      end
   end

   generate
      if (XLEN == 64) begin : g_henv
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               henv_en <= 1'b0;
            else if (wr_any && csr_addr == A_HENVCFG)
               henv_en <= wd_env;
         end
      end else begin : g_no_henv
         assign henv_en = 1'b0;
      end
   endgenerate

   always_comb begin
      case (cur_priv)
         PRIV_M:  en_cur = m_en;
         PRIV_S:  en_cur = menv_en;
         PRIV_U:  en_cur = senv_en;
         default: en_cur = 1'b0;
      endcase
   end

   // R10
   wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!HAS_LPAD) |=> (!m_en && !menv_en && !senv_en));

endmodule

// File: rtl/lpad_save_regs.sv
module lpad_save_regs
   import lpad_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit HAS_LPAD = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        armed,
   input  logic        trap_enter,
   input  logic [1:0]  trap_tgt_priv,
   input  logic        trap_ret,
   input  logic [1:0]  trap_ret_priv,
   input  logic        csr_we,
   input  logic [11:0] csr_addr,
   input  logic        wd_s,
   input  logic        wd_m,
   output logic        ssave,
   output logic        msave,
   output logic        restore
);

   localparam logic [11:0] MS_ADDR = msave_addr(XLEN);

   logic tgt_m, ret_m, s_wr, m_wr;
   logic ssave_d, msave_d;

   assign tgt_m = (trap_tgt_priv == PRIV_M);
   assign ret_m = (trap_ret_priv == PRIV_M);
   assign s_wr  = csr_we && HAS_LPAD && (csr_addr == A_MSTATUS || csr_addr == A_SSTATUS);
   assign m_wr  = csr_we && HAS_LPAD && (csr_addr == MS_ADDR);

   always_comb begin
      ssave_d = ssave;
      msave_d = msave;
      if (s_wr) ssave_d = wd_s;
      if (m_wr) msave_d = wd_m;
      if (trap_enter) begin
         if (tgt_m) msave_d = armed;
         else       ssave_d = armed;
      end else if (trap_ret) begin
         if (ret_m) msave_d = 1'b0;
         else       ssave_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ssave <= 1'b0;
         msave <= 1'b0;
      end else begin
         ssave <= ssave_d;
         msave <= msave_d;
      end
   end

   assign restore = ret_m ? msave : ssave;

   // R6
   save_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> ($past(tgt_m) ? (msave == $past(armed)) : (ssave == $past(armed))));

   // R7
   ret_clears_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_ret && !trap_enter) |=> ($past(ret_m) ? !msave : !ssave));

endmodule

// File: rtl/lpad_state_fsm.sv
module lpad_state_fsm
   import lpad_pkg::*;
#(
   parameter int CAUSE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_cur,
   input  logic               rt_valid,
   input  logic [1:0]         rt_kind,
   input  logic               trap_enter,
   input  logic               trap_ret,
   input  logic               restore,
   output logic               armed,
   output logic               viol,
   output logic [CAUSE_W-1:0] cause
);

   logic armed_d, viol_d, rt_live;

   assign rt_live = rt_valid && !trap_enter && !trap_ret;

   always_comb begin
      armed_d = armed;
      viol_d  = 1'b0;
      if (trap_enter) begin
         armed_d = 1'b0;
      end else if (trap_ret) begin
         armed_d = restore;
      end else if (rt_valid) begin
         if (armed) begin
            if (rt_kind == RK_LPAD) armed_d = 1'b0;
            else                    viol_d  = 1'b1;
         end else if (rt_kind == RK_INDIRECT) begin
            armed_d = en_cur;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         viol  <= 1'b0;
      end else begin
         armed <= armed_d;
         viol  <= viol_d;
      end
   end

   assign cause = viol ? CAUSE_W'(SWCHK_CAUSE) : '0;

   // R2
   arm_on_indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_live && !armed && rt_kind == RK_INDIRECT && en_cur) |=> armed);

   // R3
   stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_live && !armed && !en_cur) |=> !armed);

   // R4
   lpad_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_live && armed && rt_kind == RK_LPAD) |=> (!armed && !viol));

   // R4
   stray_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_live && armed && rt_kind != RK_LPAD) |=> (armed && viol));

   // R6
   trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> (!armed && !viol));

   // R4
   viol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol && !rt_valid) |=> !viol);

endmodule

// File: rtl/lpad_tracker.sv
module lpad_tracker
   import lpad_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit HAS_LPAD = 1'b1,
   parameter int CAUSE_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cur_priv,
   input  logic               rt_valid,
   input  logic [1:0]         rt_kind,
   input  logic               trap_enter,
   input  logic [1:0]         trap_tgt_priv,
   input  logic               trap_ret,
   input  logic [1:0]         trap_ret_priv,
   input  logic               csr_we,
   input  logic [11:0]        csr_addr,
   input  logic [XLEN-1:0]    csr_wdata,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               lp_expected,
   output logic               viol_valid,
   output logic [CAUSE_W-1:0] viol_cause
);

   localparam int          MS_BIT  = msave_bit(XLEN);
   localparam logic [11:0] MS_ADDR = msave_addr(XLEN);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("lpad_tracker: XLEN must be 32 or 64");
      end
      if (CAUSE_W < 5) begin : g_bad_cause
         $error("lpad_tracker: CAUSE_W too narrow for the cause code");
      end
   endgenerate

   logic m_en, menv_en, senv_en, henv_en, en_cur;
   logic ssave, msave, restore, armed;
   logic unused_wdata;

   assign unused_wdata = ^csr_wdata;

   lpad_cfg_regs #(.XLEN(XLEN), .HAS_LPAD(HAS_LPAD)) cfg_i (
      .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv),
      .csr_we(csr_we), .csr_addr(csr_addr),
      .wd_env(csr_wdata[B_ENV_EN]), .wd_msec(csr_wdata[B_MSEC_EN]),
      .m_en(m_en), .menv_en(menv_en), .senv_en(senv_en),
      .henv_en(henv_en), .en_cur(en_cur)
   );

   lpad_save_regs #(.XLEN(XLEN), .HAS_LPAD(HAS_LPAD)) save_i (
      .clk(clk), .rst_n(rst_n), .armed(armed),
      .trap_enter(trap_enter), .trap_tgt_priv(trap_tgt_priv),
      .trap_ret(trap_ret), .trap_ret_priv(trap_ret_priv),
      .csr_we(csr_we), .csr_addr(csr_addr),
      .wd_s(csr_wdata[B_SSAVE]), .wd_m(csr_wdata[MS_BIT]),
      .ssave(ssave), .msave(msave), .restore(restore)
   );

   lpad_state_fsm #(.CAUSE_W(CAUSE_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .en_cur(en_cur),
      .rt_valid(rt_valid), .rt_kind(rt_kind),
      .trap_enter(trap_enter), .trap_ret(trap_ret), .restore(restore),
      .armed(armed), .viol(viol_valid), .cause(viol_cause)
   );

   always_comb begin
      csr_rdata = '0;
      case (csr_addr)
         A_MSTATUS, A_SSTATUS: csr_rdata[B_SSAVE]   = ssave;
         A_MENVCFG:            csr_rdata[B_ENV_EN]  = menv_en;
         A_SENVCFG:            csr_rdata[B_ENV_EN]  = senv_en;
         A_HENVCFG:            csr_rdata[B_ENV_EN]  = henv_en;
         A_MSECCFG:            csr_rdata[B_MSEC_EN] = m_en;
         default:              csr_rdata = '0;
      endcase
      if (csr_addr == MS_ADDR) csr_rdata[MS_BIT] = msave;
   end

   assign lp_expected = armed;

   // R9
   sview_keeps_msave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_addr == A_SSTATUS && !trap_enter && !trap_ret) |=> $stable(msave));

endmodule

// File: tb/lpad_tracker_tb_top.sv
module lpad_tracker_tb_top;
   import lpad_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic [1:0]  cur_priv, rt_kind, trap_tgt_priv, trap_ret_priv;
   logic        rt_valid, trap_enter, trap_ret, csr_we;
   logic [11:0] csr_addr;
   logic [63:0] csr_wdata;

   logic [63:0] rd64, rdoff;
   logic [31:0] rd32;
   logic        lp64, lp32, lpoff, v64, v32, voff;
   logic [5:0]  c64, c32, coff;

   int checks = 0;
   int errors = 0;

   lpad_tracker #(.XLEN(64), .HAS_LPAD(1'b1), .CAUSE_W(6)) dut_i (
      .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .rt_valid(rt_valid), .rt_kind(rt_kind),
      .trap_enter(trap_enter), .trap_tgt_priv(trap_tgt_priv), .trap_ret(trap_ret),
      .trap_ret_priv(trap_ret_priv), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rd64), .lp_expected(lp64),
      .viol_valid(v64), .viol_cause(c64));

   lpad_tracker #(.XLEN(32), .HAS_LPAD(1'b1), .CAUSE_W(6)) dut_rv32_i (
      .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .rt_valid(rt_valid), .rt_kind(rt_kind),
      .trap_enter(trap_enter), .trap_tgt_priv(trap_tgt_priv), .trap_ret(trap_ret),
      .trap_ret_priv(trap_ret_priv), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata[31:0]), .csr_rdata(rd32), .lp_expected(lp32),
      .viol_valid(v32), .viol_cause(c32));

   lpad_tracker #(.XLEN(64), .HAS_LPAD(1'b0), .CAUSE_W(6)) dut_off_i (
      .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .rt_valid(rt_valid), .rt_kind(rt_kind),
      .trap_enter(trap_enter), .trap_tgt_priv(trap_tgt_priv), .trap_ret(trap_ret),
      .trap_ret_priv(trap_ret_priv), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdoff), .lp_expected(lpoff),
      .viol_valid(voff), .viol_cause(coff));

   localparam logic [63:0] BIT23 = 64'h0000_0000_0080_0000;
   localparam logic [63:0] BIT41 = 64'h0000_0200_0000_0000;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [11:0] a);
      csr_addr = a;
      #1;
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      step();
      csr_we = 1'b0;
   endtask

   task automatic retire(input logic [1:0] kind, input logic [1:0] priv);
      cur_priv = priv; rt_valid = 1'b1; rt_kind = kind;
      step();
      rt_valid = 1'b0;
   endtask

   task automatic trap_in(input logic [1:0] tgt);
      trap_enter = 1'b1; trap_tgt_priv = tgt;
      step();
      trap_enter = 1'b0;
   endtask

   task automatic trap_back(input logic [1:0] from);
      trap_ret = 1'b1; trap_ret_priv = from;
      step();
      trap_ret = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 live state", {63'd0, lp64}, 64'd0);
      chk("R1 viol", {63'd0, v64}, 64'd0);
      chk("R1 cause", {58'd0, c64}, 64'd0);
      rd(A_MSTATUS); chk("R1 status", rd64, 64'd0);
      rd(A_MENVCFG); chk("R1 menv", rd64, 64'd0);
      rd(A_SENVCFG); chk("R1 senv", rd64, 64'd0);
      rd(A_MSECCFG); chk("R1 msec", rd64, 64'd0);
   endtask

   task automatic t_modes();
      retire(RK_INDIRECT, PRIV_M);
      chk("R3 M disabled", {63'd0, lp64}, 64'd0);
      csr_wr(A_MSECCFG, 64'h400);
      rd(A_MSECCFG); chk("R2 msec readback", rd64, 64'h400);
      retire(RK_INDIRECT, PRIV_M);
      chk("R2 M arms", {63'd0, lp64}, 64'd1);
      retire(RK_LPAD, PRIV_M);
      chk("R4 lpad disarms", {63'd0, lp64}, 64'd0);
      chk("R4 no viol on lpad", {63'd0, v64}, 64'd0);
      retire(RK_INDIRECT, PRIV_S);
      chk("R3 S uses menvcfg", {63'd0, lp64}, 64'd0);
      csr_wr(A_MENVCFG, 64'h4);
      retire(RK_INDIRECT, PRIV_S);
      chk("R2 S arms", {63'd0, lp64}, 64'd1);
      retire(RK_LPAD, PRIV_S);
      retire(RK_INDIRECT, PRIV_U);
      chk("R3 U uses senvcfg", {63'd0, lp64}, 64'd0);
      csr_wr(A_SENVCFG, 64'h4);
      retire(RK_INDIRECT, PRIV_U);
      chk("R2 U arms", {63'd0, lp64}, 64'd1);
      retire(RK_LPAD, PRIV_U);
      retire(RK_INDIRECT, PRIV_H);
      chk("R2 mode 2 never arms", {63'd0, lp64}, 64'd0);
   endtask

   task automatic t_stray();
      retire(RK_INDIRECT, PRIV_M);
      retire(RK_OTHER, PRIV_M);
      chk("R4 viol raised", {63'd0, v64}, 64'd1);
      chk("R4 cause 18", {58'd0, c64}, 64'd18);
      chk("R4 stays armed", {63'd0, lp64}, 64'd1);
      step();
      chk("R4 viol one cycle", {63'd0, v64}, 64'd0);
      chk("R4 cause cleared", {58'd0, c64}, 64'd0);
      retire(RK_INDIRECT, PRIV_M);
      chk("R4 second indirect viol", {63'd0, v64}, 64'd1);
      retire(RK_LPAD, PRIV_M);
      chk("R4 disarm after viol", {63'd0, lp64}, 64'd0);
   endtask

   task automatic t_idle();
      retire(RK_LPAD, PRIV_M);
      chk("R5 idle lpad state", {63'd0, lp64}, 64'd0);
      chk("R5 idle lpad viol", {63'd0, v64}, 64'd0);
      retire(RK_OTHER, PRIV_M);
      chk("R5 idle other viol", {63'd0, v64}, 64'd0);
   endtask

   task automatic t_trap();
      retire(RK_INDIRECT, PRIV_M);
      trap_in(PRIV_S);
      chk("R6 live cleared", {63'd0, lp64}, 64'd0);
      rd(A_MSTATUS); chk("R6 S save", rd64, BIT23);
      trap_back(PRIV_S);
      chk("R7 S restore", {63'd0, lp64}, 64'd1);
      rd(A_MSTATUS); chk("R7 S saved cleared", rd64, 64'd0);
      trap_in(PRIV_M);
      chk("R6 live cleared M", {63'd0, lp64}, 64'd0);
      rd(A_MSTATUS); chk("R6 M save", rd64, BIT41);
      trap_back(PRIV_M);
      chk("R7 M restore", {63'd0, lp64}, 64'd1);
      rd(A_MSTATUS); chk("R7 M saved cleared", rd64, 64'd0);
      retire(RK_LPAD, PRIV_M);
      csr_wr(A_MSTATUS, BIT23);
      trap_in(PRIV_S);
      rd(A_MSTATUS); chk("R6 idle saves 0", rd64, 64'd0);
   endtask

   task automatic t_prio();
      retire(RK_INDIRECT, PRIV_M);
      rt_valid = 1'b1; rt_kind = RK_OTHER;
      trap_in(PRIV_S);
      rt_valid = 1'b0;
      chk("R8 retire ignored no viol", {63'd0, v64}, 64'd0);
      chk("R8 trap wins state", {63'd0, lp64}, 64'd0);
      rd(A_MSTATUS); chk("R8 saved armed", rd64, BIT23);
      rt_valid = 1'b1; rt_kind = RK_LPAD;
      trap_back(PRIV_S);
      rt_valid = 1'b0;
      chk("R8 return beats lpad", {63'd0, lp64}, 64'd1);
      retire(RK_LPAD, PRIV_M);
   endtask

   task automatic t_hw_wins();
      retire(RK_INDIRECT, PRIV_M);
      csr_we = 1'b1; csr_addr = A_MSTATUS; csr_wdata = 64'd0;
      trap_in(PRIV_S);
      csr_we = 1'b0;
      rd(A_MSTATUS); chk("R12 trap save beats write", rd64, BIT23);
      csr_we = 1'b1; csr_addr = A_MSTATUS; csr_wdata = BIT23;
      trap_back(PRIV_S);
      csr_we = 1'b0;
      rd(A_MSTATUS); chk("R12 return clear beats write", rd64, 64'd0);
      retire(RK_LPAD, PRIV_M);
   endtask

   task automatic t_sview();
      csr_wr(A_MSTATUS, BIT41);
      rd(A_SSTATUS); chk("R9 sview hides bit41", rd64, 64'd0);
      csr_wr(A_SSTATUS, '1);
      rd(A_MSTATUS); chk("R9 sview sets 23 keeps 41", rd64, BIT23 | BIT41);
      rd(A_SSTATUS); chk("R9 sview shows 23", rd64, BIT23);
      csr_wr(A_SSTATUS, 64'd0);
      rd(A_MSTATUS); chk("R9 sview clears 23 keeps 41", rd64, BIT41);
      csr_wr(A_MSTATUS, 64'd0);
   endtask

   task automatic t_xlen();
      csr_wr(A_HENVCFG, 64'h4);
      rd(A_HENVCFG);
      chk("R11 henv 64", rd64, 64'h4);
      chk("R11 henv 32", {32'd0, rd32}, 64'd0);
      csr_wr(A_MSTATUSH, 64'h200);
      rd(A_MSTATUSH);
      chk("R11 rv32 high save bit", {32'd0, rd32}, 64'h200);
      chk("R11 unmapped on 64", rd64, 64'd0);
      rd(12'h123); chk("R11 unmapped addr", rd64, 64'd0);
   endtask

   task automatic t_off();
      csr_wr(A_MSECCFG, '1);
      csr_wr(A_MENVCFG, '1);
      csr_wr(A_SENVCFG, '1);
      csr_wr(A_MSTATUS, '1);
      rd(A_MSECCFG); chk("R10 msec off", rdoff, 64'd0);
      rd(A_MENVCFG); chk("R10 menv off", rdoff, 64'd0);
      rd(A_SENVCFG); chk("R10 senv off", rdoff, 64'd0);
      rd(A_MSTATUS); chk("R10 status off", rdoff, 64'd0);
      retire(RK_INDIRECT, PRIV_M);
      chk("R10 never arms", {63'd0, lpoff}, 64'd0);
      chk("R10 on-instance arms", {63'd0, lp64}, 64'd1);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cur_priv = PRIV_M; rt_valid = 1'b0; rt_kind = RK_OTHER;
      trap_enter = 1'b0; trap_tgt_priv = PRIV_S; trap_ret = 1'b0; trap_ret_priv = PRIV_S;
      csr_we = 1'b0; csr_addr = 12'h000; csr_wdata = 64'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_stray();
      t_idle();
      t_trap();
      t_prio();
      t_hw_wins();
      t_sview();
      t_xlen();
      t_off();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule